// File: doc/BRIEF.md
# Decimating Averaging Sample Recorder

The block takes one 16-bit unsigned sample per clock and, after a trigger pulse, produces a record of a programmed number of reduced-rate output samples. Each output sample comes from a window of consecutive input samples, and a programmed code N sets the window length to N+1. With averaging enabled, the block adds up the whole window. With averaging disabled, it keeps the last sample of the window. In both cases the result is shifted right by a programmed number of steps and clipped to 16 bits.

A select input swaps the external converter samples for a built-in counting pattern. This lets a bench or bring-up flow predict every output value. The record-length code N gives N+1 output samples per record. The window code, record length, shift count and averaging mode are all captured when the trigger is accepted. Each output sample comes with a one-cycle valid strobe, and the last one also raises a record-done strobe.

Top module: `dec_avg_recorder`

## Requirements
- R1: While reset is asserted and after reset is released, `smp_o` is 0 and `smp_valid_o`, `rec_done_o` and `busy_o` are all low until a trigger is accepted.
- R2: A high `trig_i` at a clock edge while idle starts a record. `busy_o` is high from the next cycle until the cycle in which the last sample is presented, and then it goes low.
- R3: With a window code of D, each output sample consumes exactly D+1 consecutive input samples. The first input sample taken is the one present at the clock edge after the trigger edge.
- R4: With a length code of L, a record emits exactly L+1 valid strobes. `rec_done_o` is high together with the final one and at no other time.
- R5: With averaging enabled, an output equals the sum of its window's samples shifted right by the shift count.
- R6: With averaging disabled, an output equals the last sample of its window shifted right by the shift count.
- R7: The accumulator holds 2^DEC_W full-scale samples without overflow. Any shifted result above 0xFFFF is output as 0xFFFF.
- R8: A trigger while a record is in progress has no effect on that record's outputs or length.
- R9: Window code, length code, shift count and averaging mode are sampled at trigger acceptance. Changing them during a record has no effect on that record.
- R10: With `sim_sel_i` high, the source sample is a 16-bit counter. It is 0 at the first clock edge after reset release and increments by one every clock, wrapping at 2^16. The select is applied live, sample by sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one input sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | SMP_W | External converter sample, unsigned |
| sim_sel_i | input | 1 | 1 selects the built-in counting source |
| avg_en_i | input | 1 | 1 sums the window, 0 keeps the last sample |
| dec_i | input | DEC_W | Window code N, window length N+1 |
| len_i | input | LEN_W | Record length code N, N+1 outputs |
| shift_i | input | SH_W | Right-shift step count |
| trig_i | input | 1 | Start request, acted on while idle |
| smp_o | output | SMP_W | Decimated sample, held between strobes |
| smp_valid_o | output | 1 | One-cycle strobe for a new `smp_o` |
| rec_done_o | output | 1 | Strobe with the final sample of a record |
| busy_o | output | 1 | Record in progress |

## Verification
A trigger sampled at edge E0 raises `busy_o` after E0. The window for output k closes at edge E0+(k+1)(D+1), and the sample, its strobe and, for the last one, the done flag and the drop of `busy_o` all appear just after that edge. The bench reference model advances once per rising edge using the inputs that were stable before that edge. The bench compares the strobes, busy and, when strobed, the sample against the model at each following falling edge, so each expected value is read exactly one register stage after the edge that produces it. Per-record strobe counts are checked separately against L+1.

// File: rtl/drec_pkg.sv
package drec_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rec_state_e;
endpackage

// File: rtl/drec_sim_src.sv
module drec_sim_src #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sim_sel_i,
  input  logic [SMP_W-1:0] adc_i,
  output logic [SMP_W-1:0] src_o
);
  logic [SMP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign src_o = sim_sel_i ? cnt_q : adc_i;

  p_sim_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sim_sel_i && $past(sim_sel_i) && $past(rst_ni) |-> src_o == $past(src_o) + 1'b1);
endmodule

// File: rtl/drec_window.sv
module drec_window #(
  parameter int SMP_W = 16,
  parameter int DEC_W = 8,
  localparam int ACC_W = SMP_W + DEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             win_end_o,
  output logic [ACC_W-1:0] sum_o,
  output logic [SMP_W-1:0] pick_o
);
  logic [DEC_W-1:0] win_cnt_q;
  logic [ACC_W-1:0] acc_q;

  assign win_end_o = run_i && (win_cnt_q == dec_i);
  assign sum_o     = acc_q + ACC_W'(smp_i);
  assign pick_o    = smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      acc_q     <= '0;
    end else if (clr_i) begin
      win_cnt_q <= '0;
      acc_q     <= '0;
    end else if (run_i) begin
      if (win_end_o) begin
        win_cnt_q <= '0;
        acc_q     <= '0;
      end else begin
        win_cnt_q <= win_cnt_q + 1'b1;
        acc_q     <= sum_o;
      end
    end
  end

  p_win_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> win_cnt_q <= dec_i);

  // accumulated value never wraps below the previous partial sum
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !win_end_o && !clr_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/drec_scale.sv
module drec_scale #(
  parameter int SMP_W = 16,
  parameter int DEC_W = 8,
  parameter int SH_W  = 5,
  localparam int ACC_W = SMP_W + DEC_W
) (
  input  logic             avg_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [SMP_W-1:0] pick_i,
  output logic [SMP_W-1:0] val_o
);
  localparam logic [ACC_W-1:0] MAX_V = ACC_W'({SMP_W{1'b1}});

  logic [ACC_W-1:0] sel_v;
  logic [ACC_W-1:0] shf_v;

  always_comb begin
    sel_v = avg_i ? sum_i : ACC_W'(pick_i);
    shf_v = sel_v >> shift_i;
    val_o = (shf_v > MAX_V) ? {SMP_W{1'b1}} : shf_v[SMP_W-1:0];
  end
endmodule

// File: rtl/drec_ctrl.sv
module drec_ctrl
  import drec_pkg::*;
#(
  parameter int DEC_W = 8,
  parameter int LEN_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             avg_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             win_end_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             avg_o,
  output logic [DEC_W-1:0] dec_o,
  output logic [SH_W-1:0]  shift_o
);
  rec_state_e       state_q;
  logic [LEN_W-1:0] out_cnt_q;
  logic [LEN_W-1:0] len_q;

  assign busy_o  = (state_q == ST_RUN);
  assign start_o = (state_q == ST_IDLE) && trig_i;
  assign last_o  = busy_o && win_end_i && (out_cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      out_cnt_q <= '0;
      len_q     <= '0;
      dec_o     <= '0;
      shift_o   <= '0;
      avg_o     <= 1'b0;
    end else if (start_o) begin
      state_q   <= ST_RUN;
      out_cnt_q <= '0;
      len_q     <= len_i;
      dec_o     <= dec_i;
      shift_o   <= shift_i;
      avg_o     <= avg_i;
    end else if (busy_o && win_end_i) begin
      out_cnt_q <= out_cnt_q + 1'b1;
      if (last_o) state_q <= ST_IDLE;
    end
  end

  p_trig_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && trig_i && !last_o |=> busy_o && $stable(out_cnt_q) || busy_o && out_cnt_q == $past(out_cnt_q) + 1'b1);

  p_cfg_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> $stable(dec_o) && $stable(shift_o) && $stable(avg_o) && $stable(len_q));

  p_len_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> out_cnt_q <= len_q);
endmodule

// File: rtl/dec_avg_recorder.sv
module dec_avg_recorder #(
  parameter int SMP_W = 16,
  parameter int DEC_W = 8,
  parameter int LEN_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] adc_i,
  input  logic             sim_sel_i,
  input  logic             avg_en_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             trig_i,
  output logic [SMP_W-1:0] smp_o,
  output logic             smp_valid_o,
  output logic             rec_done_o,
  output logic             busy_o
);
  localparam int ACC_W = SMP_W + DEC_W;

  logic [SMP_W-1:0] src;
  logic             start, busy, last, win_end, avg_q;
  logic [DEC_W-1:0] dec_q;
  logic [SH_W-1:0]  shift_q;
  logic [ACC_W-1:0] sum;
  logic [SMP_W-1:0] pick, val;

  drec_sim_src #(.SMP_W(SMP_W)) u_src (
    .clk_i, .rst_ni, .sim_sel_i, .adc_i, .src_o(src)
  );

  drec_ctrl #(.DEC_W(DEC_W), .LEN_W(LEN_W), .SH_W(SH_W)) u_ctrl (
    .clk_i, .rst_ni, .trig_i, .avg_i(avg_en_i), .dec_i, .len_i, .shift_i,
    .win_end_i(win_end), .start_o(start), .busy_o(busy), .last_o(last),
    .avg_o(avg_q), .dec_o(dec_q), .shift_o(shift_q)
  );

  drec_window #(.SMP_W(SMP_W), .DEC_W(DEC_W)) u_win (
    .clk_i, .rst_ni, .clr_i(start), .run_i(busy), .dec_i(dec_q), .smp_i(src),
    .win_end_o(win_end), .sum_o(sum), .pick_o(pick)
  );

  drec_scale #(.SMP_W(SMP_W), .DEC_W(DEC_W), .SH_W(SH_W)) u_scale (
    .avg_i(avg_q), .shift_i(shift_q), .sum_i(sum), .pick_i(pick), .val_o(val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o       <= '0;
      smp_valid_o <= 1'b0;
      rec_done_o  <= 1'b0;
    end else begin
      smp_valid_o <= win_end;
      rec_done_o  <= last;
      if (win_end) smp_o <= val;
    end
  end

  assign busy_o = busy;

  p_done_with_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_done_o |-> smp_valid_o && !busy_o);

  p_valid_in_record_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(busy_o));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_o && $past(rst_ni) |-> $stable(smp_o));
endmodule

// File: tb/dec_avg_recorder_tb.sv
module dec_avg_recorder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc = '0;
  logic        sim_sel = 1'b0, avg_en = 1'b0, trig = 1'b0;
  logic [7:0]  dec = '0;
  logic [15:0] len = '0;
  logic [4:0]  shift = '0;
  logic [15:0] smp;
  logic        smp_valid, rec_done, busy;

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dec_avg_recorder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adc_i(adc), .sim_sel_i(sim_sel), .avg_en_i(avg_en),
    .dec_i(dec), .len_i(len), .shift_i(shift), .trig_i(trig),
    .smp_o(smp), .smp_valid_o(smp_valid), .rec_done_o(rec_done), .busy_o(busy)
  );

  // behavioural reference
  int     m_cnt, m_w, m_n;
  bit     m_act, m_avg, e_valid, e_done;
  int     m_dec, m_len, m_sh, e_smp;
  longint m_sum;
  int     valid_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; e_valid = 0; e_done = 0; e_smp = 0;
      m_w = 0; m_n = 0; m_sum = 0;
    end else begin
      int s;
      s = sim_sel ? m_cnt : int'(adc);
      m_cnt = (m_cnt + 1) % 65536;
      e_valid = 0; e_done = 0;
      if (!m_act) begin
        if (trig) begin
          m_act = 1; m_dec = dec; m_len = len; m_sh = shift; m_avg = avg_en;
          m_w = 0; m_n = 0; m_sum = 0;
        end
      end else begin
        m_sum += s;
        if (m_w == m_dec) begin
          longint v;
          v = (m_avg ? m_sum : longint'(s)) >> m_sh;
          e_smp = (v > 65535) ? 65535 : int'(v);
          e_valid = 1;
          e_done = (m_n == m_len);
          m_n++; m_w = 0; m_sum = 0;
          if (e_done) m_act = 0;
        end else m_w++;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(smp_valid == e_valid, cur_req, "smp_valid_o", smp_valid, e_valid);
    check(rec_done == e_done, (cur_req == "R1") ? "R4" : cur_req, "rec_done_o", rec_done, e_done);
    check(busy == m_act, "R2", "busy_o", busy, m_act);
    if (e_valid) check(smp == e_smp[15:0], cur_req, "smp_o", smp, e_smp);
    if (smp_valid) valid_seen++;
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && (m_act || trig); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_rec(string req, bit s, bit a, int d, int l, int sh, int exp_cnt);
    cur_req = req;
    @(negedge clk);
    sim_sel = s; avg_en = a; dec = 8'(d); len = 16'(l); shift = 5'(sh);
    valid_seen = 0;
    pulse_trig();
    wait_idle();
    check(valid_seen == exp_cnt, "R4", "strobe count", valid_seen, exp_cnt);
  endtask

  always @(negedge clk) if (!sim_sel && cur_req != "R7") adc <= 16'($urandom);

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(smp == 0 && !smp_valid && !rec_done && !busy, "R1", "outputs in reset", smp, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(smp == 0 && !busy, "R1", "idle after reset", busy, 0);

    run_rec("R10", 1, 0, 2, 3, 0, 4);     // R3 R6 counting pattern
    run_rec("R6",  0, 0, 4, 5, 3, 6);
    run_rec("R5",  0, 1, 3, 4, 2, 5);
    run_rec("R5",  1, 1, 255, 0, 8, 1);   // R7 full-width window
    cur_req = "R7";
    adc = 16'hFFFF;
    run_rec("R7",  0, 1, 15, 1, 0, 2);    // saturates
    run_rec("R7",  0, 1, 15, 0, 4, 1);    // exact full scale
    run_rec("R3",  1, 0, 0, 7, 0, 8);

    // R8: triggers during a record
    cur_req = "R8";
    sim_sel = 1; avg_en = 1; dec = 3; len = 4; shift = 1; valid_seen = 0;
    pulse_trig();
    for (int i = 0; i < 6; i++) begin repeat (2) @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0; end
    wait_idle();
    check(valid_seen == 5, "R8", "strobe count", valid_seen, 5);

    // R9: configuration changes mid-record
    cur_req = "R9";
    sim_sel = 0; avg_en = 0; dec = 1; len = 5; shift = 0; valid_seen = 0;
    pulse_trig();
    repeat (3) @(negedge clk);
    avg_en = 1; dec = 9; len = 1; shift = 4;
    wait_idle();
    check(valid_seen == 6, "R9", "strobe count", valid_seen, 6);

    // R10: live source switch during a record
    cur_req = "R10";
    sim_sel = 1; avg_en = 1; dec = 2; len = 5; shift = 0; valid_seen = 0;
    pulse_trig();
    repeat (5) @(negedge clk); sim_sel = 0;
    repeat (3) @(negedge clk); sim_sel = 1;
    wait_idle();
    check(valid_seen == 6, "R10", "strobe count", valid_seen, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule